// File: doc/BRIEF.md
# Audio DMA Position Tracker

This block follows the progress of one audio DMA channel through a ring buffer in memory. It keeps a base address, a frame register (current word position and buffer size) and a sample register (remaining samples in the current block and the reload value). A data mover asks for work by presenting a byte grant. The block decides how many bytes the burst really moves, advances its position, and signals when a block of samples has completed. It also presents the byte address where the next burst starts.

The sample format sets a shift of 0, 1 or 2, which is the stereo bit plus the 16-bit bit. Grants are trimmed to whole sample frames. A two-bit leftover register keeps the byte offset inside the current 32-bit word, so odd-sized bursts resume at the correct byte. Software selects loop mode or non-loop mode, and it can gate the channel with an enable bit and a pause bit.

Top module: `adma_pos_track`

## Requirements
- R1: After reset the base, frame and sample registers and the leftover all read zero, `mem_addr` is zero, and `burst_done` and `block_end` are low.
- R2: A write with `wr_sel` 0 loads the base address. A write with `wr_sel` 1 loads the frame register, with the position in bits 31:16 and the size (in words, minus one) in bits 15:0, and it clears the leftover. A write with `wr_sel` 2 loads the whole sample register, with the remaining count in bits 31:16 and the reload value in bits 15:0. A write with `wr_sel` 3 changes only bits 15:0 of the sample register.
- R3: `mem_addr` always equals base + position*4 + leftover.
- R4: The shift is the stereo bit plus the 16-bit bit. The grant is rounded down to a multiple of 1<<shift. A grant that rounds to zero is ignored: no `burst_done`, and no register changes.
- R5: A served grant moves the smallest of three values: the rounded grant; the buffer bytes left, (size-position+1)*4+leftover, which counts as 0 when position > size; and the block bytes, (remaining+1)<<shift. The moved count appears on `burst_bytes` with a one-cycle `burst_done` pulse in the cycle after the grant.
- R6: When the moved count equals the block bytes, the remaining count reloads from the reload value and `block_end` pulses together with `burst_done`.
- R7: Otherwise the remaining count becomes (block bytes - moved - 1) >> shift.
- R8: After a burst, the position grows by (moved + leftover) >> 2 and the leftover becomes (moved + leftover) & 3.
- R9: In loop mode (`loop_off` = 0), if the new position is greater than the size, the position becomes 0.
- R10: In non-loop mode (`loop_off` = 1), if the new position is greater than the size, the position stays at the size and does not wrap.
- R11: A grant is ignored while `chan_en` is low or `chan_pause` is high.
- R12: A register write in the same cycle as a grant takes effect, and the grant is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 base, 1 frame, 2 sample, 3 sample low half) |
| wr_data | input | WD_W (32) | Write data |
| chan_en | input | 1 | Channel enable |
| chan_pause | input | 1 | Channel pause |
| fmt_stereo | input | 1 | Stereo format bit |
| fmt_wide | input | 1 | 16-bit format bit |
| loop_off | input | 1 | 1 = non-loop mode |
| grant_valid | input | 1 | Byte grant present |
| grant_bytes | input | GRANT_W (16) | Granted byte count |
| mem_addr | output | ADDR_W (32) | Byte address of the next burst |
| burst_done | output | 1 | A grant was served last cycle |
| burst_bytes | output | MV_W (19) | Bytes moved by that burst |
| block_end | output | 1 | The block of samples completed |
| frame_base | output | ADDR_W (32) | Base address register |
| frame_count | output | 2*CNT_W (32) | Position and size |
| sample_count | output | 2*CNT_W (32) | Remaining count and reload value |
| leftover | output | 2 | Byte offset within the current word |

## Verification
The hardest state to reach is a non-zero leftover combined with a limit from the buffer end or a wrap. Only grants that are not a multiple of four bytes create a leftover, and the next frame-register write clears it again. The bench therefore chains bursts without writing the frame register in between, so that leftover values of 3 and then 1 appear on the address. Separate vectors start the position at the buffer end, and one starts it past the size. These vectors cover the wrap, the non-loop cap and a zero-byte move.

// File: rtl/adma_pkg.sv
package adma_pkg;
    typedef enum logic [1:0] {
        SEL_BASE    = 2'd0,
        SEL_FRAME   = 2'd1,
        SEL_SAMP    = 2'd2,
        SEL_SAMP_LO = 2'd3
    } adma_sel_e;

    localparam int WORD_LOG2 = 2;
endpackage

// File: rtl/adma_burst_calc.sv
module adma_burst_calc #(
    parameter int CNT_W   = 16,
    parameter int GRANT_W = 16,
    parameter int MV_W    = 19
) (
    input  logic [GRANT_W-1:0] grant_bytes,
    input  logic [1:0]         shift,
    input  logic [CNT_W-1:0]   pos,
    input  logic [CNT_W-1:0]   size,
    input  logic [CNT_W-1:0]   cur_cnt,
    input  logic [CNT_W-1:0]   reload_cnt,
    input  logic [1:0]         leftover,
    output logic [MV_W-1:0]    moved,
    output logic               grant_zero,
    output logic               block_done,
    output logic [CNT_W-1:0]   cur_next
);
    logic [MV_W-1:0] unit_mask;
    logic [MV_W-1:0] grant_al;
    logic [MV_W-1:0] block_bytes;
    logic [MV_W-1:0] words;
    logic [MV_W-1:0] buf_bytes;
    logic [MV_W-1:0] remain;

    always_comb begin
        // trim the grant to whole sample frames
        unit_mask   = (MV_W'(1) << shift) - MV_W'(1);
        grant_al    = MV_W'(grant_bytes) & ~unit_mask;
        grant_zero  = (grant_al == '0);
        block_bytes = (MV_W'(cur_cnt) + MV_W'(1)) << shift;
        // room left in the ring buffer; nothing when position is past size
        if (pos <= size) begin
            words     = MV_W'(size) - MV_W'(pos) + MV_W'(1);
            buf_bytes = (words << adma_pkg::WORD_LOG2) + MV_W'(leftover);
        end else begin
            words     = '0;
            buf_bytes = '0;
        end
        moved = grant_al;
        if (buf_bytes < moved)   moved = buf_bytes;
        if (block_bytes < moved) moved = block_bytes;
        block_done = (moved == block_bytes);
        remain     = block_bytes - moved - MV_W'(1);
        cur_next   = block_done ? reload_cnt : CNT_W'(remain >> shift);
    end
endmodule

// File: rtl/adma_pos_advance.sv
module adma_pos_advance #(
    parameter int CNT_W = 16,
    parameter int MV_W  = 19
) (
    input  logic [MV_W-1:0]  moved,
    input  logic [CNT_W-1:0] pos,
    input  logic [CNT_W-1:0] size,
    input  logic [1:0]       leftover,
    input  logic             loop_off,
    output logic [CNT_W-1:0] pos_next,
    output logic [1:0]       lo_next
);
    localparam int SUM_W = MV_W + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] target;
    logic             past_end;

    always_comb begin
        sum      = SUM_W'(moved) + SUM_W'(leftover);
        target   = SUM_W'(pos) + (sum >> adma_pkg::WORD_LOG2);
        lo_next  = sum[1:0];
        past_end = target > SUM_W'(size);
        if (!past_end)     pos_next = CNT_W'(target);
        else if (loop_off) pos_next = size;
        else               pos_next = '0;
    end
endmodule

// File: rtl/adma_addr_gen.sv
module adma_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  pos,
    input  logic [1:0]        leftover,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = base + ADDR_W'({pos, 2'b00}) + ADDR_W'(leftover);
    end
endmodule

// File: rtl/adma_pos_track.sv
module adma_pos_track #(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int GRANT_W = 16,
    localparam int WD_W   = (ADDR_W > 2*CNT_W) ? ADDR_W : 2*CNT_W,
    localparam int MV_W   = (GRANT_W > CNT_W+3) ? GRANT_W : CNT_W+3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [WD_W-1:0]    wr_data,
    input  logic               chan_en,
    input  logic               chan_pause,
    input  logic               fmt_stereo,
    input  logic               fmt_wide,
    input  logic               loop_off,
    input  logic               grant_valid,
    input  logic [GRANT_W-1:0] grant_bytes,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               burst_done,
    output logic [MV_W-1:0]    burst_bytes,
    output logic               block_end,
    output logic [ADDR_W-1:0]  frame_base,
    output logic [2*CNT_W-1:0] frame_count,
    output logic [2*CNT_W-1:0] sample_count,
    output logic [1:0]         leftover
);
    import adma_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  pos;
        logic [CNT_W-1:0]  size;
        logic [CNT_W-1:0]  cur;
        logic [CNT_W-1:0]  reload;
        logic [1:0]        lo;
        logic              done;
        logic              blk_end;
        logic [MV_W-1:0]   moved;
    } state_t;

    state_t st_d, st_q;

    logic [1:0]       shift_w;
    logic [MV_W-1:0]  moved_w;
    logic             grant_zero_w;
    logic             block_done_w;
    logic [CNT_W-1:0] cur_next_w;
    logic [CNT_W-1:0] pos_next_w;
    logic [1:0]       lo_next_w;
    logic             serve_w;

    assign shift_w = 2'(fmt_stereo) + 2'(fmt_wide);

    adma_burst_calc #(.CNT_W(CNT_W), .GRANT_W(GRANT_W), .MV_W(MV_W)) u_calc (
        .grant_bytes (grant_bytes),
        .shift       (shift_w),
        .pos         (st_q.pos),
        .size        (st_q.size),
        .cur_cnt     (st_q.cur),
        .reload_cnt  (st_q.reload),
        .leftover    (st_q.lo),
        .moved       (moved_w),
        .grant_zero  (grant_zero_w),
        .block_done  (block_done_w),
        .cur_next    (cur_next_w)
    );

    adma_pos_advance #(.CNT_W(CNT_W), .MV_W(MV_W)) u_adv (
        .moved    (moved_w),
        .pos      (st_q.pos),
        .size     (st_q.size),
        .leftover (st_q.lo),
        .loop_off (loop_off),
        .pos_next (pos_next_w),
        .lo_next  (lo_next_w)
    );

    adma_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .base     (st_q.base),
        .pos      (st_q.pos),
        .leftover (st_q.lo),
        .addr     (mem_addr)
    );

    assign serve_w = grant_valid && chan_en && !chan_pause && !grant_zero_w;

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.blk_end = 1'b0;
        st_d.moved   = '0;
        if (wr_en) begin
            // a write wins; any grant this cycle is dropped
            case (adma_sel_e'(wr_sel))
                SEL_BASE:  st_d.base = wr_data[ADDR_W-1:0];
                SEL_FRAME: begin
                    st_d.pos  = wr_data[2*CNT_W-1:CNT_W];
                    st_d.size = wr_data[CNT_W-1:0];
                    st_d.lo   = 2'd0;
                end
                SEL_SAMP: begin
                    st_d.cur    = wr_data[2*CNT_W-1:CNT_W];
                    st_d.reload = wr_data[CNT_W-1:0];
                end
                default:   st_d.reload = wr_data[CNT_W-1:0];
            endcase
        end else if (serve_w) begin
            st_d.done    = 1'b1;
            st_d.moved   = moved_w;
            st_d.blk_end = block_done_w;
            st_d.cur     = cur_next_w;
            st_d.pos     = pos_next_w;
            st_d.lo      = lo_next_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign burst_done   = st_q.done;
    assign burst_bytes  = st_q.moved;
    assign block_end    = st_q.blk_end;
    assign frame_base   = st_q.base;
    assign frame_count  = {st_q.pos, st_q.size};
    assign sample_count = {st_q.cur, st_q.reload};
    assign leftover     = st_q.lo;

    // R11: a gated grant leaves counters alone
    p_gate_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !(chan_en && !chan_pause) && !wr_en)
        |=> (!burst_done && $stable(frame_count) && $stable(sample_count)));

    // R12: a write cycle never yields a burst
    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !burst_done);

    // R6: block completion leaves remaining equal to reload
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        block_end |-> (sample_count[2*CNT_W-1:CNT_W] == sample_count[CNT_W-1:0]));

    // R6: block_end only accompanies a burst
    p_end_with_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        block_end |-> burst_done);

    // R10: non-loop bursts never leave the position beyond the size
    p_nonloop_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_done && $past(loop_off))
        |-> (frame_count[2*CNT_W-1:CNT_W] <= frame_count[CNT_W-1:0]));

    // R5: never more bytes than granted
    p_moved_le_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> (burst_bytes <= MV_W'($past(grant_bytes))));

    // R2: a frame write clears the leftover
    p_frame_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> (leftover == 2'd0));
endmodule

// File: tb/tb_adma_pos_track.sv
module tb_adma_pos_track;
    localparam int NV = 9;
    localparam logic [31:0] BASE = 32'h1000_0000;

    // cfg = {stereo, wide, loop_off}
    localparam logic [31:0] V_FIN [NV] = '{32'h0000_000F, 32'h0000_000F, 32'h0000_000F,
        32'h0000_000F, 32'h000E_000F, 32'h000E_000F, 32'h0003_000F, 32'h0014_000F, 32'h0000_000F};
    localparam logic [31:0] V_SIN [NV] = '{32'h0007_0007, 32'h0007_0007, 32'h0003_0009,
        32'h0063_0063, 32'h0063_0063, 32'h0063_0063, 32'h0004_0004, 32'h0005_0005, 32'h0001_0003};
    localparam logic [2:0]  V_CFG [NV] = '{3'b000, 3'b000, 3'b110, 3'b010, 3'b000, 3'b001,
        3'b110, 3'b000, 3'b100};
    localparam logic [15:0] V_GNT [NV] = '{16'd8, 16'd5, 16'd23, 16'd7, 16'd100, 16'd100,
        16'd3, 16'd10, 16'd9};
    localparam logic        V_DONE[NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [18:0] V_MOV [NV] = '{19'd8, 19'd5, 19'd16, 19'd6, 19'd8, 19'd8,
        19'd0, 19'd0, 19'd4};
    localparam logic        V_END [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [31:0] V_FOUT[NV] = '{32'h0002_000F, 32'h0001_000F, 32'h0004_000F,
        32'h0001_000F, 32'h0000_000F, 32'h000F_000F, 32'h0003_000F, 32'h0000_000F, 32'h0001_000F};
    localparam logic [31:0] V_SOUT[NV] = '{32'h0007_0007, 32'h0002_0007, 32'h0009_0009,
        32'h0060_0063, 32'h005B_0063, 32'h005B_0063, 32'h0004_0004, 32'h0005_0005, 32'h0003_0003};
    localparam logic [1:0]  V_LO  [NV] = '{2'd0, 2'd1, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
    localparam string       V_TAG [NV] = '{"R6 block end", "R7 partial", "R4 R6 shift2 round",
        "R4 R7 shift1", "R5 R9 buffer wrap", "R10 non-loop cap", "R4 rounds to zero",
        "R5 R9 past size", "R4 R6 stereo"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        chan_en = 1'b0, chan_pause = 1'b0;
    logic        fmt_stereo = 1'b0, fmt_wide = 1'b0, loop_off = 1'b0;
    logic        grant_valid = 1'b0;
    logic [15:0] grant_bytes = '0;
    logic [31:0] mem_addr;
    logic        burst_done, block_end;
    logic [18:0] burst_bytes;
    logic [31:0] frame_base, frame_count, sample_count;
    logic [1:0]  leftover;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adma_pos_track dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .chan_en(chan_en), .chan_pause(chan_pause), .fmt_stereo(fmt_stereo),
        .fmt_wide(fmt_wide), .loop_off(loop_off), .grant_valid(grant_valid),
        .grant_bytes(grant_bytes), .mem_addr(mem_addr), .burst_done(burst_done),
        .burst_bytes(burst_bytes), .block_end(block_end), .frame_base(frame_base),
        .frame_count(frame_count), .sample_count(sample_count), .leftover(leftover)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic grant(input logic [15:0] g);
        @(negedge clk);
        grant_valid = 1'b1; grant_bytes = g;
        @(negedge clk);
        grant_valid = 1'b0;
    endtask

    function automatic logic [31:0] addr_of(input logic [31:0] base, input logic [31:0] fc,
                                            input logic [1:0] lo);
        return base + {14'd0, fc[31:16], 2'b00} + {30'd0, lo};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 base", frame_base, 32'h0);
        chk("R1 frame", frame_count, 32'h0);
        chk("R1 sample", sample_count, 32'h0);
        chk("R1 addr", mem_addr, 32'h0);
        chk("R1 flags", {29'd0, burst_done, block_end, |leftover}, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            chan_en = 1'b1; chan_pause = 1'b0;
            {fmt_stereo, fmt_wide, loop_off} = V_CFG[i];
            reg_write(2'd0, BASE);
            reg_write(2'd1, V_FIN[i]);
            reg_write(2'd2, V_SIN[i]);
            grant(V_GNT[i]);
            chk({V_TAG[i], " R5 done"}, {31'd0, burst_done}, {31'd0, V_DONE[i]});
            if (V_DONE[i]) chk({V_TAG[i], " R5 moved"}, {13'd0, burst_bytes}, {13'd0, V_MOV[i]});
            chk({V_TAG[i], " R6 end"}, {31'd0, block_end}, {31'd0, V_END[i]});
            chk({V_TAG[i], " R7 sample"}, sample_count, V_SOUT[i]);
            chk({V_TAG[i], " R8 frame"}, frame_count, V_FOUT[i]);
            chk({V_TAG[i], " R8 leftover"}, {30'd0, leftover}, {30'd0, V_LO[i]});
            chk({V_TAG[i], " R3 addr"}, mem_addr, addr_of(BASE, V_FOUT[i], V_LO[i]));
        end

        // R2 low-half sample write
        reg_write(2'd2, 32'h1234_5678);
        reg_write(2'd3, 32'hAAAA_9999);
        chk("R2 low half", sample_count, 32'h1234_9999);

        // R8 leftover chaining, R3 address with leftover, R2 clear
        {fmt_stereo, fmt_wide, loop_off} = 3'b000;
        reg_write(2'd0, BASE);
        reg_write(2'd1, 32'h0000_000F);
        reg_write(2'd2, 32'h0063_0063);
        grant(16'd3);
        chk("R8 lo after 3", {30'd0, leftover}, 32'd3);
        chk("R3 addr +3", mem_addr, BASE + 32'd3);
        grant(16'd2);
        chk("R8 frame after 5", frame_count, 32'h0001_000F);
        chk("R8 lo after 5", {30'd0, leftover}, 32'd1);
        chk("R3 addr +5", mem_addr, BASE + 32'd5);
        chk("R7 remaining", sample_count, 32'h005E_0063);
        reg_write(2'd1, 32'h0000_000F);
        chk("R2 frame write clears lo", {30'd0, leftover}, 32'd0);
        reg_write(2'd0, 32'h2000_0000);
        chk("R3 new base", mem_addr, 32'h2000_0000);

        // R11 gating
        chan_en = 1'b0;
        grant(16'd8);
        chk("R11 disabled done", {31'd0, burst_done}, 32'd0);
        chk("R11 disabled frame", frame_count, 32'h0000_000F);
        chan_en = 1'b1; chan_pause = 1'b1;
        grant(16'd8);
        chk("R11 paused done", {31'd0, burst_done}, 32'd0);
        chk("R11 paused sample", sample_count, 32'h005E_0063);
        chan_pause = 1'b0;

        // R12 write and grant together
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h0002_0002;
        grant_valid = 1'b1; grant_bytes = 16'd4;
        @(negedge clk);
        wr_en = 1'b0; grant_valid = 1'b0;
        chk("R12 no burst", {31'd0, burst_done}, 32'd0);
        chk("R12 write applied", sample_count, 32'h0002_0002);
        chk("R12 frame untouched", frame_count, 32'h0000_000F);

        // R5 pulse lasts one cycle
        grant(16'd3);
        chk("R5 moved 3", {13'd0, burst_bytes}, 32'd3);
        chk("R6 end on 3", {31'd0, block_end}, 32'd1);
        @(negedge clk);
        chk("R5 pulse clears", {31'd0, burst_done}, 32'd0);

        // R1 reset clears everything again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 re-reset sample", sample_count, 32'h0);
        chk("R1 re-reset addr", mem_addr, 32'h0);

        finish_run();
    end
endmodule